// File: doc/BRIEF.md
# Operand-Pair Instruction Dispatcher

This block sits between an in-order stream of fixed-format two-operand instructions and a group of processing elements. Each element owns a small local copy of a subset of the scratchpad registers. The subsets form a balanced incomplete block layout: every register sits in the same number of elements, and any two distinct registers share exactly one element. The dispatcher looks only at the unordered pair of register fields and routes the instruction to the one element that holds both operands. It hands over the instruction together with both operand values, read from that element's local copy.

Write-back results come in on a separate port. A write to a register updates, in a single clock edge, every element copy of that register, so that all replicas stay identical. The default layout has seven registers and seven elements of three registers each. The layout is produced from a cyclic difference set: element k holds registers k, k+1 and k+3, wrapping modulo 7 and numbered from 1. This gives element 1 = {1,2,4}, 2 = {2,3,5}, 3 = {3,4,6}, 4 = {4,5,7}, 5 = {5,6,1}, 6 = {6,7,2} and 7 = {7,1,3}.

Top module: `opd_top`

## Requirements
- R1: The instruction word is {opcode[3:0], regA[2:0], regB[2:0]}, with the opcode in the most significant bits and regB in the least significant bits. Registers are numbered 1..7. When regA and regB differ, the instruction goes to the single element holding both, whatever the operand order. Element k is shown on `outValid` bit k-1.
- R2: When regA equals regB, the instruction goes to the lowest-numbered element that holds that register.
- R3: For an instruction with valid fields, `inReady` equals the `outReady` bit of the selected element. `outValid` of that element stays asserted whether or not it is ready.
- R4: At most one `outValid` bit is high at any time. No bit is high while `inValid` is low.
- R5: A register field equal to 0 or greater than 7 raises `errFlag`. The instruction is then dropped: no `outValid`, and `inReady` is high whatever the `outReady` values are.
- R6: A write-back to a valid register raises `replicaWe` for exactly the elements that hold it. A write-back naming register 0 raises no `replicaWe` bit and changes no stored value.
- R7: After a write-back edge, every element holding the register returns the new value as an operand.
- R8: A write-back and a dispatch that reads the same register in the same cycle return the write-back data on that operand (write-first bypass).
- R9: After reset all replicas read as zero and no `outValid` or `errFlag` is high while the input is idle.
- R10: `outInstr` carries the accepted instruction word unchanged. `outOpA` and `outOpB` carry the values of regA and regB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Instruction taken (dispatched or dropped) |
| inInstr | input | 10 | Opcode and two register fields |
| outValid | output | 7 | Per-element instruction valid |
| outReady | input | 7 | Per-element ready |
| outInstr | output | 10 | Instruction word shared by all element channels |
| outOpA | output | 16 | Value of the first operand register |
| outOpB | output | 16 | Value of the second operand register |
| errFlag | output | 1 | Register field out of range; instruction dropped |
| wbValid | input | 1 | Write-back present |
| wbReg | input | 3 | Register written back |
| wbData | input | 16 | Value written back |
| replicaWe | output | 7 | Per-element replica write strobe |

## Verification
The hardest situation to reach is a register update that lands in some replicas and misses others. The element chosen for an instruction depends on its operand pair, so one read reveals only a single copy. The stimulus therefore writes a distinct value into every register. It then reads each register through every element that holds it, choosing for each element a partner register whose pair routes there. This reaches all 21 copies from the ports. A same-cycle write and read of one register checks the bypass, and a write to register 0 confirms that no copy moved.

// File: rtl/opd_pkg.sv
`timescale 1ns/1ps
package opd_pkg;

  // Strobes from the control into the replica datapath.
  typedef struct packed {
    logic       dispatch;  // valid instruction with legal fields
    logic       drop;      // valid instruction with an illegal field
    logic [3:0] selIdx;    // zero-based element chosen by the pair lookup
    logic [1:0] slotA;     // slot of regA inside the chosen element
    logic [1:0] slotB;     // slot of regB inside the chosen element
    logic       bypassA;   // same-cycle write-back hits regA
    logic       bypassB;   // same-cycle write-back hits regB
  } opd_strobe_t;

  // Register number (1-based) held in a given slot of a given element
  // for a cyclic layout built from a difference-set offset.
  function automatic int heldReg(int pe, int offset, int nRegs);
    return ((pe + offset) % nRegs) + 1;
  endfunction

endpackage

// File: rtl/opd_ctrl.sv
`timescale 1ns/1ps
module opd_ctrl
  import opd_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int REGS_PER_PE = 3,
  parameter logic [REGS_PER_PE*8-1:0] DIFF_SET = {8'd3, 8'd1, 8'd0},
  parameter int REG_W       = 3
) (
  input  logic                inValid,
  input  logic [REG_W-1:0]    regA,
  input  logic [REG_W-1:0]    regB,
  input  logic [NUM_REGS-1:0] outReady,
  input  logic                wbValid,
  input  logic [REG_W-1:0]    wbReg,
  output opd_strobe_t         strobes,
  output logic [NUM_REGS-1:0] outValid,
  output logic                inReady,
  output logic                errFlag,
  output logic [NUM_REGS-1:0] weOneHot
);

  localparam int NUM_PES = NUM_REGS;

  function automatic logic [REG_W-1:0] regAt(int pe, int s);
    int off;
    off = int'(DIFF_SET[s*8 +: 8]);
    return REG_W'(heldReg(pe, off, NUM_REGS));
  endfunction

  function automatic logic inRange(logic [REG_W-1:0] r);
    return (r != '0) && (int'(r) <= NUM_REGS);
  endfunction

  logic                aOk, bOk, wbOk, fieldsOk;
  logic [NUM_PES-1:0]  hasA, hasB, hasWb, pairHit;
  logic [NUM_PES-1:0]  selOneHot;
  int                  selPe;

  // Membership of each operand and of the write-back register per element.
  always_comb begin
    hasA  = '0;
    hasB  = '0;
    hasWb = '0;
    for (int pe = 0; pe < NUM_PES; pe++) begin
      for (int s = 0; s < REGS_PER_PE; s++) begin
        if (regAt(pe, s) == regA)  hasA[pe]  = 1'b1;
        if (regAt(pe, s) == regB)  hasB[pe]  = 1'b1;
        if (regAt(pe, s) == wbReg) hasWb[pe] = 1'b1;
      end
    end
  end

  assign aOk      = inRange(regA);
  assign bOk      = inRange(regB);
  assign wbOk     = inRange(wbReg);
  assign fieldsOk = aOk && bOk;
  assign pairHit  = hasA & hasB;

  // Lowest element holding both operands. For distinct operands there is
  // only one; for a repeated operand this picks the lowest holder.
  always_comb begin
    selPe = 0;
    for (int pe = NUM_PES - 1; pe >= 0; pe--) begin
      if (pairHit[pe]) selPe = pe;
    end
    selOneHot = '0;
    if (fieldsOk) selOneHot[selPe] = 1'b1;
  end

  // Slot of each operand within the chosen element, and the bypass.
  always_comb begin
    strobes          = '0;
    strobes.dispatch = inValid && fieldsOk;
    strobes.drop     = inValid && !fieldsOk;
    strobes.selIdx   = 4'(selPe);
    for (int s = 0; s < REGS_PER_PE; s++) begin
      if (regAt(selPe, s) == regA) strobes.slotA = 2'(s);
      if (regAt(selPe, s) == regB) strobes.slotB = 2'(s);
    end
    strobes.bypassA  = wbValid && wbOk && (wbReg == regA);
    strobes.bypassB  = wbValid && wbOk && (wbReg == regB);
  end

  assign outValid = strobes.dispatch ? selOneHot : '0;
  assign inReady  = !fieldsOk || (|(selOneHot & outReady));
  assign errFlag  = strobes.drop;
  assign weOneHot = (wbValid && wbOk) ? hasWb : '0;

endmodule

// File: rtl/opd_datapath.sv
`timescale 1ns/1ps
module opd_datapath
  import opd_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int REGS_PER_PE = 3,
  parameter logic [REGS_PER_PE*8-1:0] DIFF_SET = {8'd3, 8'd1, 8'd0},
  parameter int REG_W       = 3,
  parameter int DATA_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  opd_strobe_t         strobes,
  input  logic [NUM_REGS-1:0] weOneHot,
  input  logic [REG_W-1:0]    wbReg,
  input  logic [DATA_W-1:0]   wbData,
  output logic [DATA_W-1:0]   outOpA,
  output logic [DATA_W-1:0]   outOpB
);

  localparam int NUM_PES   = NUM_REGS;
  localparam int NUM_CELLS = NUM_PES * REGS_PER_PE;

  logic [NUM_CELLS*DATA_W-1:0] cellFlat;

  // One storage cell per (element, slot): every replica is a real copy.
  for (genvar pe = 0; pe < NUM_PES; pe++) begin : g_pe
    for (genvar s = 0; s < REGS_PER_PE; s++) begin : g_slot
      localparam int HELD_OFF = int'(DIFF_SET[s*8 +: 8]);
      localparam logic [REG_W-1:0] HELD = REG_W'(heldReg(pe, HELD_OFF, NUM_REGS));
      logic [DATA_W-1:0] cellQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cellQ <= '0;
        else if (weOneHot[pe] && (wbReg == HELD))
          cellQ <= wbData;
      end
      assign cellFlat[(pe*REGS_PER_PE + s)*DATA_W +: DATA_W] = cellQ;
    end
  end

  // Read the chosen element's local copies, with write-first bypass.
  logic [DATA_W-1:0] readA, readB;
  always_comb begin
    readA = '0;
    readB = '0;
    for (int pe = 0; pe < NUM_PES; pe++) begin
      for (int s = 0; s < REGS_PER_PE; s++) begin
        if (strobes.selIdx == 4'(pe) && strobes.slotA == 2'(s))
          readA = cellFlat[(pe*REGS_PER_PE + s)*DATA_W +: DATA_W];
        if (strobes.selIdx == 4'(pe) && strobes.slotB == 2'(s))
          readB = cellFlat[(pe*REGS_PER_PE + s)*DATA_W +: DATA_W];
      end
    end
  end

  assign outOpA = strobes.bypassA ? wbData : readA;
  assign outOpB = strobes.bypassB ? wbData : readB;

endmodule

// File: rtl/opd_top.sv
`timescale 1ns/1ps
module opd_top
  import opd_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int REGS_PER_PE = 3,
  parameter logic [REGS_PER_PE*8-1:0] DIFF_SET = {8'd3, 8'd1, 8'd0},
  parameter int OP_W        = 4,
  parameter int DATA_W      = 16,
  localparam int REG_W      = $clog2(NUM_REGS + 1),
  localparam int INSTR_W    = OP_W + 2*REG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [INSTR_W-1:0]  inInstr,
  output logic [NUM_REGS-1:0] outValid,
  input  logic [NUM_REGS-1:0] outReady,
  output logic [INSTR_W-1:0]  outInstr,
  output logic [DATA_W-1:0]   outOpA,
  output logic [DATA_W-1:0]   outOpB,
  output logic                errFlag,
  input  logic                wbValid,
  input  logic [REG_W-1:0]    wbReg,
  input  logic [DATA_W-1:0]   wbData,
  output logic [NUM_REGS-1:0] replicaWe
);

  opd_strobe_t       strobes;
  logic [REG_W-1:0]  regA, regB;

  assign regA     = inInstr[2*REG_W-1:REG_W];
  assign regB     = inInstr[REG_W-1:0];
  assign outInstr = inInstr;

  opd_ctrl #(
    .NUM_REGS(NUM_REGS), .REGS_PER_PE(REGS_PER_PE),
    .DIFF_SET(DIFF_SET), .REG_W(REG_W)
  ) u_ctrl (
    .inValid (inValid),
    .regA    (regA),
    .regB    (regB),
    .outReady(outReady),
    .wbValid (wbValid),
    .wbReg   (wbReg),
    .strobes (strobes),
    .outValid(outValid),
    .inReady (inReady),
    .errFlag (errFlag),
    .weOneHot(replicaWe)
  );

  opd_datapath #(
    .NUM_REGS(NUM_REGS), .REGS_PER_PE(REGS_PER_PE),
    .DIFF_SET(DIFF_SET), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .weOneHot(replicaWe),
    .wbReg   (wbReg),
    .wbData  (wbData),
    .outOpA  (outOpA),
    .outOpB  (outOpB)
  );

endmodule

// File: rtl/opd_checker.sv
`timescale 1ns/1ps
module opd_checker #(
  parameter int NUM_REGS = 7,
  parameter int REPLICAS = 3,
  parameter int REG_W    = 3,
  parameter int INSTR_W  = 10,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [INSTR_W-1:0]  inInstr,
  input logic [NUM_REGS-1:0] outValid,
  input logic [NUM_REGS-1:0] outReady,
  input logic [DATA_W-1:0]   outOpA,
  input logic                errFlag,
  input logic                wbValid,
  input logic [REG_W-1:0]    wbReg,
  input logic [DATA_W-1:0]   wbData,
  input logic [NUM_REGS-1:0] replicaWe
);

  logic [REG_W-1:0] chkRegA;
  logic             armed;
  logic             wbLegal;

  assign chkRegA = inInstr[2*REG_W-1:REG_W];
  assign wbLegal = (wbReg != '0) && (int'(wbReg) <= NUM_REGS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_single_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (outValid == '0));

  p_error_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (outValid == '0) && inReady);

  p_ready_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) |-> (inReady == (|(outValid & outReady))));

  p_fanout_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbLegal) |-> ($countones(replicaWe) == REPLICAS));

  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wbValid && wbLegal) |-> (replicaWe == '0));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((|outValid) && wbValid && wbLegal && (wbReg == chkRegA))
      |-> (outOpA == wbData));

  p_persist_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wbValid) && ($past(wbReg) != '0)
       && (int'($past(wbReg)) <= NUM_REGS)
       && (|outValid) && (chkRegA == $past(wbReg))
       && !(wbValid && (wbReg == chkRegA)))
      |-> (outOpA == $past(wbData)));

endmodule

bind opd_top opd_checker #(
  .NUM_REGS(NUM_REGS), .REPLICAS(REGS_PER_PE), .REG_W(REG_W),
  .INSTR_W(INSTR_W), .DATA_W(DATA_W)
) u_opd_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inInstr  (inInstr),
  .outValid (outValid),
  .outReady (outReady),
  .outOpA   (outOpA),
  .errFlag  (errFlag),
  .wbValid  (wbValid),
  .wbReg    (wbReg),
  .wbData   (wbData),
  .replicaWe(replicaWe)
);

// File: tb/test_opd_top.sv
`timescale 1ns/1ps
module test_opd_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [9:0]  inInstr;
  logic [6:0]  outValid;
  logic [6:0]  outReady;
  logic [9:0]  outInstr;
  logic [15:0] outOpA, outOpB;
  logic        errFlag;
  logic        wbValid;
  logic [2:0]  wbReg;
  logic [15:0] wbData;
  logic [6:0]  replicaWe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] model [8];

  // Element k (1-based) holds the three registers of row k-1.
  int lineTab [7][3] = '{'{1,2,4}, '{2,3,5}, '{3,4,6}, '{4,5,7},
                         '{5,6,1}, '{6,7,2}, '{7,1,3}};

  always #2 clk = ~clk;

  opd_top i_opd_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inInstr(inInstr), .outValid(outValid), .outReady(outReady),
    .outInstr(outInstr), .outOpA(outOpA), .outOpB(outOpB),
    .errFlag(errFlag), .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .replicaWe(replicaWe)
  );

  function automatic bit holds(int pe, int r);
    for (int s = 0; s < 3; s++) if (lineTab[pe][s] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int expPe(int a, int b);
    for (int pe = 0; pe < 7; pe++) if (holds(pe, a) && holds(pe, b)) return pe;
    return -1;
  endfunction

  function automatic logic [6:0] holderMask(int r);
    logic [6:0] m = '0;
    for (int pe = 0; pe < 7; pe++) if (holds(pe, r)) m[pe] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(int op, int a, int b);
    @(negedge clk);
    inValid = 1'b1;
    inInstr = {4'(op), 3'(a), 3'(b)};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid  = 1'b0;
    wbValid  = 1'b0;
    outReady = '1;
  endtask

  task automatic t_reset();
    rstN = 1'b0; inValid = 1'b0; inInstr = '0; outReady = '1;
    wbValid = 1'b0; wbReg = '0; wbData = '0;
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9", "idle outValid", 32'(outValid), 0);
    check("R9", "idle errFlag", 32'(errFlag), 0);
    for (int pe = 0; pe < 7; pe++) begin
      drive(1, lineTab[pe][0], lineTab[pe][2]);
      check("R9", "reset operand A", 32'(outOpA), 0);
      check("R9", "reset operand B", 32'(outOpB), 0);
    end
    idle();
  endtask

  task automatic t_routing();
    for (int a = 1; a <= 7; a++) begin
      for (int b = 1; b <= 7; b++) begin
        if (a != b) begin
          drive((a + b) % 16, a, b);
          check("R1", "pair target", 32'(outValid), 32'(7'(1) << expPe(a, b)));
          check("R10", "instr passthrough", 32'(outInstr),
                32'({4'((a + b) % 16), 3'(a), 3'(b)}));
          check("R1", "no error", 32'(errFlag), 0);
        end
      end
    end
    idle();
  endtask

  task automatic t_same_reg();
    for (int r = 1; r <= 7; r++) begin
      int low = -1;
      for (int pe = 6; pe >= 0; pe--) if (holds(pe, r)) low = pe;
      drive(2, r, r);
      check("R2", "repeated operand target", 32'(outValid), 32'(7'(1) << low));
    end
    idle();
  endtask

  task automatic t_stall();
    int pe;
    pe = expPe(3, 6);
    @(negedge clk);
    outReady = ~(7'(1) << pe);
    drive(5, 3, 6);
    check("R3", "stall ready", 32'(inReady), 0);
    check("R3", "valid held while stalled", 32'(outValid), 32'(7'(1) << pe));
    @(negedge clk);
    outReady = 7'(1) << pe;
    #1;
    check("R3", "release ready", 32'(inReady), 1);
    @(negedge clk);
    outReady = ~(7'(1) << ((pe + 1) % 7));
    #1;
    check("R3", "other element busy", 32'(inReady), 1);
    idle();
    #1;
    check("R4", "no valid when idle", 32'(outValid), 0);
  endtask

  task automatic t_error();
    @(negedge clk);
    outReady = '0;
    drive(3, 0, 3);
    check("R5", "err regA zero", 32'(errFlag), 1);
    check("R5", "dropped no valid", 32'(outValid), 0);
    check("R5", "dropped ready", 32'(inReady), 1);
    drive(3, 5, 0);
    check("R5", "err regB zero", 32'(errFlag), 1);
    check("R5", "dropped no valid B", 32'(outValid), 0);
    drive(3, 0, 0);
    check("R5", "err both zero", 32'(errFlag), 1);
    check("R5", "dropped ready both", 32'(inReady), 1);
    idle();
  endtask

  task automatic t_broadcast();
    for (int r = 1; r <= 7; r++) begin
      @(negedge clk);
      inValid = 1'b0;
      wbValid = 1'b1; wbReg = 3'(r); wbData = 16'(16'h1100 * r + 16'h5);
      #1;
      check("R6", "replica write mask", 32'(replicaWe), 32'(holderMask(r)));
      @(posedge clk);
      model[r] = 16'(16'h1100 * r + 16'h5);
    end
    @(negedge clk);
    wbValid = 1'b1; wbReg = 3'd0; wbData = 16'hDEAD;
    #1;
    check("R6", "illegal write mask", 32'(replicaWe), 0);
    @(posedge clk);
    @(negedge clk);
    wbValid = 1'b0;
    for (int pe = 0; pe < 7; pe++) begin
      for (int s = 0; s < 3; s++) begin
        int m = lineTab[pe][s];
        int o = lineTab[pe][(s + 1) % 3];
        drive(7, m, o);
        check("R7", "read routed", 32'(outValid), 32'(7'(1) << pe));
        check("R7", "replica value A", 32'(outOpA), 32'(model[m]));
        check("R10", "replica value B", 32'(outOpB), 32'(model[o]));
      end
    end
    idle();
  endtask

  task automatic t_bypass();
    @(negedge clk);
    wbValid = 1'b1; wbReg = 3'd4; wbData = 16'hBEEF;
    inValid = 1'b1; inInstr = {4'd9, 3'd4, 3'd6};
    #1;
    check("R8", "bypass operand A", 32'(outOpA), 32'h0000BEEF);
    check("R8", "other operand unchanged", 32'(outOpB), 32'(model[6]));
    @(posedge clk);
    model[4] = 16'hBEEF;
    @(negedge clk);
    wbValid = 1'b0;
    inInstr = {4'd9, 3'd7, 3'd4};
    #1;
    check("R7", "value kept after bypass", 32'(outOpB), 32'h0000BEEF);
    idle();
  endtask

  initial begin
    t_reset();
    t_routing();
    t_same_reg();
    t_stall();
    t_error();
    t_broadcast();
    t_bypass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule